// File: doc/BRIEF.md
# Two-Group Channel Request Arbiter

This block arbitrates I/O channel transactions between two resource groups that run side by side. The poll group takes interrupt-poll requests from the processor and cycle-steal requests from a parameterised set of channel devices. The service group takes direct-program-control requests from the processor, plus requests that the poll group forwards to it. Each group owns at most one transaction at a time. It holds the grant until its completion strobe and chooses its next winner only on a clock edge where it is free.

Requests may be single-cycle pulses. A request that cannot be granted at once is latched and waits until it wins. When the poll group grants a transaction whose source flags that it needs the service resources, a forwarded request goes to the service group. The poll group then stays occupied until the service group finishes that forwarded transaction. The processor must never raise interrupt-poll and direct-program-control in the same cycle; when it does, the block flags a protocol error one cycle later. An asynchronous reset clears both groups at once.

Top module: `chan_arb_top`

## Requirements
- R1: Each group holds at most one grant at a time, and a group's busy output is high exactly when one of its grants is high.
- R2: In the poll group, any cycle-steal request beats a simultaneous interrupt-poll request. Among cycle-steal sources the lowest index wins when CS_ORDER is PICK_LOW_FIRST (the default); the highest index wins when it is PICK_HIGH_FIRST. Bit k of `cs_req` and `cs_gnt` belong to device k.
- R3: In the service group, a pending forwarded request beats a simultaneous direct-program-control request.
- R4: A grant stays high until the clock edge that samples its group's done strobe. Busy is low in the cycle after that edge, and the next grant of that group appears no earlier than the edge after that.
- R5: A request pulse that arrives while its group is busy, or that loses, is held pending. All pending requests are arbitrated together on the first edge at which the group is free.
- R6: Both groups can hold independent transactions at the same time, and the done strobe of one group does not change the grant of the other.
- R7: When the poll group grants a source whose service flag (`ipoll_svc` or bit k of `cs_svc`) is high at the grant edge, `fwd_pend` rises at that same edge and falls at the edge where the service group grants `fwd_gnt`. The poll grant then stays high, ignoring `poll_done`, until the edge that samples `svc_done` while `fwd_gnt` is high. Both groups free on that edge.
- R8: `proto_err` is high for exactly the cycle after a cycle in which `ipoll_req` and `dpc_req` were both high, and low otherwise. Both requests are still handled normally.
- R9: An active-low `rst_n` clears every grant, busy output, pending request, forwarded request and error flag immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ipoll_req | input | 1 | Processor interrupt-poll request pulse |
| ipoll_svc | input | 1 | Interrupt-poll transaction needs the service group |
| cs_req | input | NUM_CS | Cycle-steal request pulses, one per device |
| cs_svc | input | NUM_CS | Per-device flag: transaction needs the service group |
| poll_done | input | 1 | Completion strobe for a non-forwarded poll transaction |
| dpc_req | input | 1 | Processor direct-program-control request pulse |
| svc_done | input | 1 | Completion strobe for the service group |
| ipoll_gnt | output | 1 | Interrupt-poll grant |
| cs_gnt | output | NUM_CS | Cycle-steal grants, one-hot or zero |
| dpc_gnt | output | 1 | Direct-program-control grant |
| fwd_gnt | output | 1 | Service group is running a forwarded poll transaction |
| fwd_pend | output | 1 | Forwarded request waiting at the service group |
| poll_busy | output | 1 | Poll group holds a transaction |
| svc_busy | output | 1 | Service group holds a transaction |
| proto_err | output | 1 | Interrupt-poll and direct-program-control were seen together |

## Verification
A lost pending latch shows as a request that never gets a grant after its group frees. This is visible two edges after the done strobe that should have let it through. A wrong priority or a grant that clears early shows on the grant lines at the very next edge. A broken forwarding link shows as a poll grant that drops on `poll_done`, or that survives the service completion, within one cycle. Reset defects show in the same cycle that reset is asserted, or as a stale request that is granted just after release.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;

   // Order in which equal-class requesters are ranked inside a picker.
   typedef enum logic {
      PICK_LOW_FIRST  = 1'b0,
      PICK_HIGH_FIRST = 1'b1
   } pick_order_e;

   localparam int unsigned MAX_CS = 16;

endpackage

// File: rtl/chan_arb_pick.sv
module chan_arb_pick
   import chan_arb_pkg::*;
#(
   parameter int unsigned W     = 4,
   parameter pick_order_e ORDER = PICK_LOW_FIRST
) (
   input  logic [W-1:0] req_i,
   output logic [W-1:0] gnt_o,
   output logic         any_o
);

   if (W < 1) begin : g_bad_width
      $error("chan_arb_pick: W must be at least 1");
   end

   assign any_o = |req_i;

   if (ORDER == PICK_LOW_FIRST) begin : g_low
      // Scan downward so the last hit is the lowest index.
      always_comb begin
         gnt_o = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
               gnt_o    = '0;
               gnt_o[i] = 1'b1;
            end
         end
      end
   end else begin : g_high
      // Scan upward so the last hit is the highest index.
      always_comb begin
         gnt_o = '0;
         for (int i = 0; i < W; i++) begin
            if (req_i[i]) begin
               gnt_o    = '0;
               gnt_o[i] = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/chan_arb_hold.sv
module chan_arb_hold #(
   parameter int unsigned W = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] req_i,
   input  logic [W-1:0] take_i,
   output logic [W-1:0] cand_o
);

   if (W < 1) begin : g_bad_width
      $error("chan_arb_hold: W must be at least 1");
   end

   logic [W-1:0] pend_q;

   for (genvar k = 0; k < W; k++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pend_q[k] <= 1'b0;
         end else begin
            pend_q[k] <= (pend_q[k] | req_i[k]) & ~take_i[k];
         end
      end

      assign cand_o[k] = pend_q[k] | req_i[k];

      // R5: a contender that is not taken is still waiting next cycle
      p_keep_pending_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (cand_o[k] && !take_i[k]) |=> pend_q[k]);

      // R5: a taken contender leaves no residue unless it is requested again
      p_clear_on_take_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         take_i[k] |=> (cand_o[k] == req_i[k]));
   end

endmodule

// File: rtl/chan_arb_poll.sv
module chan_arb_poll
   import chan_arb_pkg::*;
#(
   parameter int unsigned NUM_CS = 4,
   parameter pick_order_e ORDER  = PICK_LOW_FIRST
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ipoll_req_i,
   input  logic              ipoll_svc_i,
   input  logic [NUM_CS-1:0] cs_req_i,
   input  logic [NUM_CS-1:0] cs_svc_i,
   input  logic              done_i,
   input  logic              fwd_take_i,
   input  logic              fwd_done_i,
   output logic              ipoll_gnt_o,
   output logic [NUM_CS-1:0] cs_gnt_o,
   output logic              busy_o,
   output logic              fwd_req_o
);

   if (NUM_CS < 1 || NUM_CS > MAX_CS) begin : g_bad_cs
      $error("chan_arb_poll: NUM_CS out of range");
   end

   logic [NUM_CS-1:0] cs_cand, cs_win, cs_take;
   logic [NUM_CS-1:0] cs_gnt_q;
   logic              cs_any;
   logic              ip_cand, ip_take;
   logic              ip_gnt_q, busy_q, fwd_wait_q, fwd_req_q;
   logic              start, win_svc, release_now;

   chan_arb_hold #(.W(NUM_CS)) u_cs_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (cs_req_i),
      .take_i (cs_take),
      .cand_o (cs_cand)
   );

   chan_arb_hold #(.W(1)) u_ip_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (ipoll_req_i),
      .take_i (ip_take),
      .cand_o (ip_cand)
   );

   chan_arb_pick #(.W(NUM_CS), .ORDER(ORDER)) u_cs_pick (
      .req_i (cs_cand),
      .gnt_o (cs_win),
      .any_o (cs_any)
   );

   // Contenders are only looked at on an edge where the group is idle.
   assign start       = !busy_q && (cs_any || ip_cand);
   assign cs_take     = start ? cs_win : '0;
   assign ip_take     = start && !cs_any;
   assign win_svc     = cs_any ? |(cs_win & cs_svc_i) : ipoll_svc_i;
   assign release_now = fwd_wait_q ? fwd_done_i : done_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q     <= 1'b0;
         ip_gnt_q   <= 1'b0;
         cs_gnt_q   <= '0;
         fwd_wait_q <= 1'b0;
         fwd_req_q  <= 1'b0;
      end else if (start) begin
         busy_q     <= 1'b1;
         ip_gnt_q   <= ip_take;
         cs_gnt_q   <= cs_take;
         fwd_wait_q <= win_svc;
         fwd_req_q  <= win_svc;
      end else if (busy_q) begin
         if (fwd_take_i) begin
            fwd_req_q <= 1'b0;
         end
         if (release_now) begin
            busy_q     <= 1'b0;
            ip_gnt_q   <= 1'b0;
            cs_gnt_q   <= '0;
            fwd_wait_q <= 1'b0;
            fwd_req_q  <= 1'b0;
         end
      end
   end

   assign ipoll_gnt_o = ip_gnt_q;
   assign cs_gnt_o    = cs_gnt_q;
   assign busy_o      = busy_q;
   assign fwd_req_o   = fwd_req_q;

   // R1: busy means exactly one grant, idle means none
   p_one_grant_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> $onehot({ip_gnt_q, cs_gnt_q}));
   p_idle_no_grant_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q |-> ({ip_gnt_q, cs_gnt_q} == '0));

   // R2: a cycle-steal contender at a free edge always beats interrupt poll
   p_cs_beats_ip_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_q && cs_any) |=> (|cs_gnt_q && !ip_gnt_q));

   // R4: grant held until done; group idle right after done
   p_hold_grant_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !release_now) |=> (busy_q && $stable({ip_gnt_q, cs_gnt_q})));
   p_free_after_done_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && release_now) |=> !busy_q);

   // R7: a forwarded transaction ignores the poll done strobe
   p_fwd_ignores_done_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_wait_q && done_i && !fwd_done_i) |=> busy_q);
   p_fwd_req_needs_busy_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_req_q |-> (busy_q && fwd_wait_q));

endmodule

// File: rtl/chan_arb_svc.sv
module chan_arb_svc
   import chan_arb_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic dpc_req_i,
   input  logic fwd_req_i,
   input  logic done_i,
   output logic dpc_gnt_o,
   output logic fwd_gnt_o,
   output logic busy_o,
   output logic fwd_take_o,
   output logic fwd_done_o
);

   logic       dpc_cand, dpc_take;
   logic [1:0] win;
   logic       any, start;
   logic       busy_q, dpc_gnt_q, fwd_gnt_q;

   chan_arb_hold #(.W(1)) u_dpc_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (dpc_req_i),
      .take_i (dpc_take),
      .cand_o (dpc_cand)
   );

   // Bit 0 is the forwarded request, so low-first ranking favours it.
   chan_arb_pick #(.W(2), .ORDER(PICK_LOW_FIRST)) u_pick (
      .req_i ({dpc_cand, fwd_req_i}),
      .gnt_o (win),
      .any_o (any)
   );

   assign start      = !busy_q && any;
   assign dpc_take   = start && win[1];
   assign fwd_take_o = start && win[0];
   assign fwd_done_o = busy_q && fwd_gnt_q && done_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q    <= 1'b0;
         dpc_gnt_q <= 1'b0;
         fwd_gnt_q <= 1'b0;
      end else if (start) begin
         busy_q    <= 1'b1;
         dpc_gnt_q <= win[1];
         fwd_gnt_q <= win[0];
      end else if (busy_q && done_i) begin
         busy_q    <= 1'b0;
         dpc_gnt_q <= 1'b0;
         fwd_gnt_q <= 1'b0;
      end
   end

   assign dpc_gnt_o = dpc_gnt_q;
   assign fwd_gnt_o = fwd_gnt_q;
   assign busy_o    = busy_q;

   // R1: one grant while busy, none while idle
   p_svc_one_grant_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q == (dpc_gnt_q ^ fwd_gnt_q));
   p_svc_not_both_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dpc_gnt_q && fwd_gnt_q));

   // R3: a waiting forwarded request wins the next free edge
   p_fwd_first_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_q && fwd_req_i) |=> fwd_gnt_q);

   // R4: grant held until done, idle right after done
   p_svc_hold_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !done_i) |=> (busy_q && $stable({dpc_gnt_q, fwd_gnt_q})));
   p_svc_free_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && done_i) |=> !busy_q);

endmodule

// File: rtl/chan_arb_top.sv
module chan_arb_top
   import chan_arb_pkg::*;
#(
   parameter int unsigned NUM_CS   = 4,
   parameter pick_order_e CS_ORDER = PICK_LOW_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ipoll_req,
   input  logic              ipoll_svc,
   input  logic [NUM_CS-1:0] cs_req,
   input  logic [NUM_CS-1:0] cs_svc,
   input  logic              poll_done,
   input  logic              dpc_req,
   input  logic              svc_done,
   output logic              ipoll_gnt,
   output logic [NUM_CS-1:0] cs_gnt,
   output logic              dpc_gnt,
   output logic              fwd_gnt,
   output logic              fwd_pend,
   output logic              poll_busy,
   output logic              svc_busy,
   output logic              proto_err
);

   logic fwd_take, fwd_done, fwd_req;
   logic err_q;

   chan_arb_poll #(.NUM_CS(NUM_CS), .ORDER(CS_ORDER)) u_poll (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ipoll_req_i (ipoll_req),
      .ipoll_svc_i (ipoll_svc),
      .cs_req_i    (cs_req),
      .cs_svc_i    (cs_svc),
      .done_i      (poll_done),
      .fwd_take_i  (fwd_take),
      .fwd_done_i  (fwd_done),
      .ipoll_gnt_o (ipoll_gnt),
      .cs_gnt_o    (cs_gnt),
      .busy_o      (poll_busy),
      .fwd_req_o   (fwd_req)
   );

   chan_arb_svc u_svc (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .dpc_req_i  (dpc_req),
      .fwd_req_i  (fwd_req),
      .done_i     (svc_done),
      .dpc_gnt_o  (dpc_gnt),
      .fwd_gnt_o  (fwd_gnt),
      .busy_o     (svc_busy),
      .fwd_take_o (fwd_take),
      .fwd_done_o (fwd_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else begin
         err_q <= ipoll_req & dpc_req;
      end
   end

   assign fwd_pend  = fwd_req;
   assign proto_err = err_q;

   // R8: both processor requests together raise the flag next cycle
   p_proto_err_set_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (ipoll_req && dpc_req) |=> proto_err);
   p_proto_err_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(ipoll_req && dpc_req) |=> !proto_err);

   // R7: forwarded transaction keeps both groups tied until service completes
   p_fwd_holds_poll_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      fwd_gnt |-> poll_busy);
   p_fwd_done_frees_both_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_gnt && svc_done) |=> (!poll_busy && !svc_busy));

   // R6: a poll done strobe alone leaves a direct-program grant untouched
   p_groups_independent_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (dpc_gnt && !svc_done) |=> dpc_gnt);

endmodule

// File: tb/chan_arb_top_tb_top.sv
`timescale 1ns/1ps
module chan_arb_top_tb_top;

   localparam int NCS = 4;
   localparam int NV  = 22;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ipoll_req = 1'b0, ipoll_svc = 1'b0;
   logic [NCS-1:0] cs_req = '0, cs_svc = '0;
   logic           poll_done = 1'b0, dpc_req = 1'b0, svc_done = 1'b0;
   logic           ipoll_gnt, dpc_gnt, fwd_gnt, fwd_pend;
   logic           poll_busy, svc_busy, proto_err;
   logic [NCS-1:0] cs_gnt;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   chan_arb_top #(.NUM_CS(NCS)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ipoll_req (ipoll_req),
      .ipoll_svc (ipoll_svc),
      .cs_req    (cs_req),
      .cs_svc    (cs_svc),
      .poll_done (poll_done),
      .dpc_req   (dpc_req),
      .svc_done  (svc_done),
      .ipoll_gnt (ipoll_gnt),
      .cs_gnt    (cs_gnt),
      .dpc_gnt   (dpc_gnt),
      .fwd_gnt   (fwd_gnt),
      .fwd_pend  (fwd_pend),
      .poll_busy (poll_busy),
      .svc_busy  (svc_busy),
      .proto_err (proto_err)
   );

   // Row layout, MSB first:
   //   tag[4] | ip ips cs[4] css[4] pdone dpc sdone |
   //   e_ip e_cs[4] e_dpc e_fwd e_pbusy e_sbusy e_fpend e_err
   // Expected fields are the outputs after the edge that samples the row.
   localparam logic [27:0] VEC [NV] = '{
      28'b1001_0_0_0000_0000_0_0_0_0_0000_0_0_0_0_0_0, // V0  R9 idle after reset
      28'b0010_1_0_0100_0000_0_0_0_0_0100_0_0_1_0_0_0, // V1  R2 cs2 beats ipoll
      28'b0101_0_0_0001_0000_0_0_0_0_0100_0_0_1_0_0_0, // V2  R5 cs0 arrives while busy
      28'b0100_0_0_0000_0000_1_0_0_0_0000_0_0_0_0_0_0, // V3  R4 done frees poll
      28'b0010_0_0_0000_0000_0_0_0_0_0001_0_0_1_0_0_0, // V4  R2 pending cs0 beats ipoll
      28'b0100_0_0_0000_0000_1_0_0_0_0000_0_0_0_0_0_0, // V5  R4 done
      28'b0101_0_0_0000_0000_0_0_0_1_0000_0_0_1_0_0_0, // V6  R5 held ipoll granted
      28'b0110_0_0_0000_0000_0_1_0_1_0000_1_0_1_1_0_0, // V7  R6 both groups busy
      28'b0110_0_0_0000_0000_1_0_0_0_0000_1_0_0_1_0_0, // V8  R6 poll done leaves dpc
      28'b0111_0_0_1000_1000_0_0_0_0_1000_1_0_1_1_1_0, // V9  R7 forward raised
      28'b0111_0_0_0000_0000_1_0_0_0_1000_1_0_1_1_1_0, // V10 R7 poll done ignored
      28'b0100_0_0_0000_0000_0_0_1_0_1000_0_0_1_0_1_0, // V11 R4 service frees
      28'b0011_0_0_0000_0000_0_1_0_0_1000_0_1_1_1_0_0, // V12 R3 forward beats dpc
      28'b0111_0_0_0000_0000_0_0_1_0_0000_0_0_0_0_0_0, // V13 R7 both free together
      28'b0101_0_0_0000_0000_0_0_0_0_0000_1_0_0_1_0_0, // V14 R5 held dpc granted
      28'b1000_1_0_0000_0000_0_1_0_1_0000_1_0_1_1_0_1, // V15 R8 ipoll and dpc together
      28'b0100_0_0_0000_0000_1_0_1_0_0000_0_0_0_0_0_0, // V16 R4 both done
      28'b0101_0_0_0000_0000_0_0_0_0_0000_1_0_0_1_0_0, // V17 R5 dpc held through V15
      28'b0100_0_0_0000_0000_0_0_1_0_0000_0_0_0_0_0_0, // V18 R4 done
      28'b0111_1_1_0000_0000_0_0_0_1_0000_0_0_1_0_1_0, // V19 R7 ipoll needing service
      28'b0111_0_0_0000_0000_0_0_0_1_0000_0_1_1_1_0_0, // V20 R7 forward taken
      28'b0111_0_0_0000_0000_0_0_1_0_0000_0_0_0_0_0_0  // V21 R7 all free
   };

   function automatic logic [10:0] observe();
      return {ipoll_gnt, cs_gnt, dpc_gnt, fwd_gnt, poll_busy, svc_busy, fwd_pend, proto_err};
   endfunction

   task automatic check(input string req, input logic [10:0] got, input logic [10:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b (ip cs dpc fwd pb sb fp err)", req, got, exp);
      end
   endtask

   task automatic drive(input logic ip, input logic ips, input logic [NCS-1:0] cs,
                        input logic [NCS-1:0] css, input logic pd, input logic dpc,
                        input logic sd);
      ipoll_req = ip;  ipoll_svc = ips; cs_req = cs; cs_svc = css;
      poll_done = pd;  dpc_req = dpc;   svc_done = sd;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin : main
      logic [27:0] v;
      drive(0, 0, '0, '0, 0, 0, 0);
      #1;
      check("R9 outputs during reset", observe(), 11'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Table walk
      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         drive(v[23], v[22], v[21:18], v[17:14], v[13], v[12], v[11]);
         step();
         drive(0, 0, '0, '0, 0, 0, 0);
         check($sformatf("R%0d vector %0d", v[27:24], i), observe(), v[10:0]);
      end

      // R2 and R5: four cycle-steal pulses at once drain in index order
      drive(0, 0, 4'b1111, '0, 0, 0, 0);
      step();
      drive(0, 0, '0, '0, 0, 0, 0);
      for (int k = 0; k < NCS; k++) begin
         check($sformatf("R2 burst grant %0d", k), observe(),
               {1'b0, 4'(1 << k), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
         // R1: exactly one grant while busy
         n_checks++;
         if ($countones({ipoll_gnt, cs_gnt}) != 1) begin
            n_fail++;
            $display("FAIL R1 grant count: got %0d expected 1", $countones({ipoll_gnt, cs_gnt}));
         end
         drive(0, 0, '0, '0, 1, 0, 0);
         step();
         drive(0, 0, '0, '0, 0, 0, 0);
         check($sformatf("R4 free after burst done %0d", k), observe(), 11'b0);
         step();
      end
      check("R5 burst fully drained", observe(), 11'b0);

      // R9: asynchronous reset with grants held and a request pending
      drive(0, 0, 4'b0010, '0, 0, 1, 0);
      step();
      drive(0, 0, 4'b1000, '0, 0, 0, 0);
      step();
      drive(0, 0, '0, '0, 0, 0, 0);
      check("R9 setup before reset", observe(), {1'b0, 4'b0010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});
      #2;
      rst_n = 1'b0;
      #1;
      check("R9 cleared without clock", observe(), 11'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      step();
      check("R9 pending request discarded", observe(), 11'b0);

      finished = 1;
      summary();
      $finish;
   end

endmodule